// File: doc/BRIEF.md
# Random-Point CRT Plot Sequencer

This block takes one point-plot command at a time for a randomly addressed 1024 by 1024 CRT and turns it into deflection codes and an intensity level. Each command carries signed-style 10-bit X and Y offsets, a 2-bit origin selector that says which screen landmark the offsets are measured from, a 3-bit brightness code whose numeric order is not its visual order, and a flag that tells whether the issuer waits for the plot.

Once accepted, the command's translated position and intensity are held on the outputs for a fixed plot window of 40 microseconds, counted in clock cycles through the `TICKS_PER_US` parameter. One microsecond before the window closes, a strobe samples the light-pen input; light at that instant sets a sticky pen flag that stays until a clear input. Commands arriving during a plot are held off through the ready handshake rather than lost.

Top module: `crt_point_plotter`

## Requirements
- R1: After reset, busy, done, stall and pen_flag are 0, cmd_ready is 1, and defl_x, defl_y and intensity are 0.
- R2: Deflection codes are absolute screen positions with 0,0 at the lower-left corner, modulo 1024: origin 0 (centre) gives X+512, Y+512; origin 1 (bottom-edge centre) gives X+512, Y; origin 2 (left-edge middle) gives X, Y+512; origin 3 (lower-left) gives X, Y.
- R3: intensity is the visual rank 0 (dimmest) to 7 (brightest) of the brightness code, whose dim-to-bright order is 4, 5, 6, 7, 0, 1, 2, 3, so code 4 gives 0, code 0 gives 4 and code 3 gives 7.
- R4: A command is accepted on a clock edge where cmd_valid and cmd_ready are both 1; busy is then 1 for exactly 40*TICKS_PER_US cycles, and done is a one-cycle pulse in the last of them.
- R5: cmd_ready is 0 while busy; a command presented during a plot is not taken until the plot ends and is then accepted with its own fields.
- R6: defl_x, defl_y and intensity keep the accepted command's values through the whole plot and after it, whatever the command inputs do meanwhile.
- R7: stall is 1 throughout the plot of a command issued with cmd_wait = 1 and stays 0 for a command issued with cmd_wait = 0.
- R8: The pen strobe falls in busy cycle 39*TICKS_PER_US (counting the first busy cycle as 1); pen_flag is set after that cycle only if pen_light is 1 in it, and light in any other cycle has no effect.
- R9: pen_flag stays 1 until pen_clear is 1 for a cycle; if the strobe sees light in the same cycle as pen_clear, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Block can take a command |
| cmd_x | input | 10 | X offset from the selected origin |
| cmd_y | input | 10 | Y offset from the selected origin |
| cmd_bright | input | 3 | Brightness code |
| cmd_origin | input | 2 | Origin selector |
| cmd_wait | input | 1 | 1 = issuer waits for completion |
| pen_light | input | 1 | Light-pen sees light |
| pen_clear | input | 1 | Clear the pen flag |
| defl_x | output | 10 | Absolute X deflection code |
| defl_y | output | 10 | Absolute Y deflection code |
| intensity | output | 3 | Visual brightness rank |
| busy | output | 1 | Plot in progress |
| done | output | 1 | One-cycle completion pulse |
| stall | output | 1 | Issuer must wait |
| pen_flag | output | 1 | Sticky light-pen hit |

## Verification
The bench sweeps every origin and brightness code against coordinates at 0, mid-scale and full-scale, so a swapped origin axis or a monotonic brightness mapping shows up as wrong deflection or intensity codes at the wrap points. It counts busy cycles and the done position on each plot, catching an off-by-one window, and pulses the pen one cycle before, at and after the strobe, so a strobe in the wrong cycle sets the flag when it should not or misses it. It also offers a second command during a plot, which a design that dropped or overwrote it would lose or change mid-plot, and races pen_clear against a strobe hit.

// File: rtl/crt_point_plotter.sv
module crt_point_plotter #(
  parameter int TICKS_PER_US = 1,
  parameter int PLOT_US      = 40,
  parameter int STROBE_US    = 39
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_valid,
  output logic       cmd_ready,
  input  logic [9:0] cmd_x,
  input  logic [9:0] cmd_y,
  input  logic [2:0] cmd_bright,
  input  logic [1:0] cmd_origin,
  input  logic       cmd_wait,
  input  logic       pen_light,
  input  logic       pen_clear,
  output logic [9:0] defl_x,
  output logic [9:0] defl_y,
  output logic [2:0] intensity,
  output logic       busy,
  output logic       done,
  output logic       stall,
  output logic       pen_flag
);
  localparam int PLOT_CYC   = PLOT_US * TICKS_PER_US;
  localparam int STROBE_CYC = STROBE_US * TICKS_PER_US;
  localparam int CW         = $clog2(PLOT_CYC + 1);

  logic [CW-1:0] cnt;
  logic          waiting;
  logic          accept, strobe;

  assign cmd_ready = !busy;
  assign accept    = cmd_valid && cmd_ready;
  assign done      = busy && (cnt == CW'(PLOT_CYC - 1));
  assign strobe    = busy && (cnt == CW'(STROBE_CYC - 1));
  assign stall     = busy && waiting;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      cnt       <= '0;
      waiting   <= 1'b0;
      defl_x    <= '0;
      defl_y    <= '0;
      intensity <= '0;
    end else if (accept) begin
      busy      <= 1'b1;
      cnt       <= '0;
      waiting   <= cmd_wait;
      defl_x    <= cmd_x ^ {!cmd_origin[1], 9'b0};
      defl_y    <= cmd_y ^ {!cmd_origin[0], 9'b0};
      intensity <= cmd_bright ^ 3'b100;
    end else if (busy) begin
      cnt <= cnt + 1'b1;
      if (done) busy <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                   pen_flag <= 1'b0;
    else if (strobe && pen_light) pen_flag <= 1'b1;
    else if (pen_clear)           pen_flag <= 1'b0;
  end

  p_accept_starts_r4: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> busy && !done);
  p_done_ends_r4: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);
  p_hold_outputs_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> busy && $stable(defl_x) && $stable(defl_y) && $stable(intensity));
  p_no_take_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> !cmd_ready);
  p_stall_in_plot_r7: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> busy);
  p_pen_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (pen_flag && !pen_clear) |=> pen_flag);
  p_pen_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pen_flag) |-> $past(pen_light) && $past(busy));
endmodule

// File: tb/crt_point_plotter_test.sv
module crt_point_plotter_test;
  localparam int CLK_PERIOD = 10;
  localparam int TICKS      = 2;
  localparam int PLOT       = 40 * TICKS;
  localparam int STROBE     = 39 * TICKS;

  logic clk = 0, rst_n = 0;
  logic cmd_valid = 0, cmd_wait = 0, pen_light = 0, pen_clear = 0;
  logic [9:0] cmd_x = 0, cmd_y = 0;
  logic [2:0] cmd_bright = 0;
  logic [1:0] cmd_origin = 0;
  logic cmd_ready, busy, done, stall, pen_flag;
  logic [9:0] defl_x, defl_y;
  logic [2:0] intensity;
  int tests = 0, fails = 0;
  bit finished = 0;

  crt_point_plotter #(.TICKS_PER_US(TICKS)) uut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_x(cmd_x), .cmd_y(cmd_y), .cmd_bright(cmd_bright), .cmd_origin(cmd_origin),
    .cmd_wait(cmd_wait), .pen_light(pen_light), .pen_clear(pen_clear),
    .defl_x(defl_x), .defl_y(defl_y), .intensity(intensity), .busy(busy),
    .done(done), .stall(stall), .pen_flag(pen_flag));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(string req, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Issue a command, run the full plot window; pulse pen_light at busy index pen_at (-1 none).
  task automatic plot(int x, int y, int b, int o, bit w, int pen_at, bit full);
    int ex, ey;
    bit ok = 1;
    ex = (o >= 2) ? x : (x ^ 512);
    ey = (o % 2 == 1) ? y : (y ^ 512);
    @(negedge clk);
    cmd_valid = 1; cmd_x = 10'(x); cmd_y = 10'(y);
    cmd_bright = 3'(b); cmd_origin = 2'(o); cmd_wait = w;
    @(posedge clk);
    @(negedge clk);
    cmd_valid = 0; cmd_x = ~cmd_x; cmd_bright = ~cmd_bright;
    check("R2 x", int'(defl_x), ex);
    check("R2 y", int'(defl_y), ey);
    check("R3", int'(intensity), b ^ 4);
    for (int k = 0; k < PLOT; k++) begin
      if (k > 0) @(negedge clk);
      pen_light = (k == pen_at);
      if (full) begin
        check("R4 busy", int'(busy), 1);
        check("R4 done", int'(done), int'(k == PLOT - 1));
        check("R7", int'(stall), int'(w));
        check("R5", int'(cmd_ready), 0);
      end else if (busy !== 1'b1 || done !== (k == PLOT - 1) || stall !== w) ok = 0;
    end
    if (!full) check("R4/R7 window", int'(ok), 1);
    @(negedge clk);
    pen_light = 0;
    check("R4 end", int'(busy), 0);
    check("R6 x", int'(defl_x), ex);
    check("R6 i", int'(intensity), b ^ 4);
  endtask

  task automatic clear_pen();
    @(negedge clk); pen_clear = 1;
    @(negedge clk); pen_clear = 0;
  endtask

  initial begin
    int xs[5] = '{0, 1, 511, 512, 1023};
    repeat (3) @(negedge clk);
    check("R1 busy", int'(busy), 0);
    check("R1 ready", int'(cmd_ready), 1);
    check("R1 pen", int'(pen_flag), 0);
    check("R1 done", int'(done), 0);
    check("R1 stall", int'(stall), 0);
    check("R1 defl", int'(defl_x) + int'(defl_y) + int'(intensity), 0);
    rst_n = 1;
    plot(100, 200, 3, 0, 1, -1, 1);
    plot(100, 200, 4, 3, 0, -1, 1);
    for (int o = 0; o < 4; o++)
      for (int b = 0; b < 8; b++)
        for (int i = 0; i < 5; i++)
          plot(xs[i], xs[4 - i], b, o, 1'((o + b + i) % 2), -1, 0);
    check("R8 no light", int'(pen_flag), 0);
    plot(5, 5, 0, 0, 0, STROBE - 2, 0);
    check("R8 early", int'(pen_flag), 0);
    plot(5, 5, 0, 0, 0, STROBE, 0);
    check("R8 late", int'(pen_flag), 0);
    plot(5, 5, 0, 0, 0, STROBE - 1, 0);
    check("R8 hit", int'(pen_flag), 1);
    plot(6, 6, 1, 1, 0, -1, 0);
    check("R9 sticky", int'(pen_flag), 1);
    clear_pen();
    @(negedge clk);
    check("R9 clear", int'(pen_flag), 0);
    // clear raced with strobe hit: set wins
    fork
      plot(7, 7, 2, 2, 0, STROBE - 1, 0);
      begin
        repeat (STROBE + 1) @(negedge clk);
        pen_clear = 1;
        @(negedge clk);
        pen_clear = 0;
      end
    join
    check("R9 race", int'(pen_flag), 1);
    clear_pen();
    // held-off command R5
    @(negedge clk);
    cmd_valid = 1; cmd_x = 10; cmd_y = 20; cmd_bright = 6; cmd_origin = 3; cmd_wait = 0;
    @(negedge clk);
    cmd_x = 300; cmd_y = 400; cmd_bright = 1; cmd_origin = 3;
    for (int k = 1; k < PLOT; k++) @(negedge clk);
    check("R5 held ready", int'(cmd_ready), 0);
    check("R6 held x", int'(defl_x), 10);
    @(negedge clk);
    check("R5 free", int'(cmd_ready), 1);
    @(negedge clk);
    cmd_valid = 0;
    check("R5 taken", int'(busy), 1);
    check("R5 x", int'(defl_x), 300);
    check("R5 y", int'(defl_y), 400);
    check("R5 i", int'(intensity), 5);
    repeat (PLOT + 2) @(negedge clk);
    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      tests++; fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule